// File: doc/BRIEF.md
# Programmable Video Clock Divider

This block turns the pixel clock into the slower clocks that the rest of a display pipeline needs. It produces a load strobe for the pixel input port whose rate follows the multiplex mode on its own, so the strobe can be wired straight back to the port's load input. It also produces a divided clock, set separately, that can drive a graphics controller's master clock or the frame-buffer shift clock. A third output gives the A/B phase that a 2:1 pixel serializer uses to pick which half of a fetched pixel pair goes out.

One free-running 5-bit count drives all three outputs, so they keep a fixed phase relationship to each other. A new divide select is held back until the count wraps to zero. This means the divided clock never shows a short pulse when the ratio changes. The multiplex-mode bit takes effect at the next clock edge.

Two small state machines sit around the counter. The select tracker has the states `SEL_HOLD` (the live ratio matches the request) and `SEL_PEND` (a different ratio waits for the wrap). Its transitions are *request-differs* (HOLD to PEND), *commit-at-wrap* (PEND to HOLD, loading the request) and *request-withdrawn* (PEND to HOLD, keeping the live ratio). The output stage has the states `OUT_IDLE` (held in reset, all outputs low) and `OUT_RUN`. Its transitions are *release* (IDLE to RUN, on the first edge with reset low) and *re-reset* (RUN to IDLE).

Top module: `vclk_divider`

## Requirements
- R1: While `rst_i` is high at a rising edge, that edge clears the count to 0 and drives `load_clk_o`, `prog_clk_o` and `pix_phase_o` low. The divide select present during reset becomes the live ratio.
- R2: In 2:1 mode (`mux2_i` = 1), `load_clk_o` is a square wave of period 2 pixel clocks. It is high while the count is even and low while it is odd. The count is 1 in the first cycle after reset is released.
- R3: In 1:1 mode (`mux2_i` = 0), `load_clk_o` is held high, so a load happens on every pixel clock, and `pix_phase_o` is held low (A only).
- R4: In 2:1 mode, `pix_phase_o` is the complement of `load_clk_o`: it is 0 (pixel A) on even counts and 1 (pixel B) on odd counts.
- R5: `prog_clk_o` divides the pixel clock by N with a 50% duty cycle. The encoding of `div_sel_i` is 00 for N=4, 01 for N=8, 10 for N=16 and 11 for N=32. The output equals bit log2(N)-1 of the count, so it rises only on even counts.
- R6: Whenever the count is 0, `prog_clk_o` is low, whatever the ratio.
- R7: A change of `div_sel_i` is sampled only at the edge where the count goes from 31 to 0. A request that is withdrawn before that edge has no effect on `prog_clk_o`.
- R8: A change of `mux2_i` shows on `load_clk_o` and `pix_phase_o` right after the next rising edge, without waiting for a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mux2_i | input | 1 | Multiplex mode: 1 = 2:1, 0 = 1:1 |
| div_sel_i | input | 2 | Ratio select for the programmable clock |
| load_clk_o | output | 1 | Load strobe for the pixel input port |
| prog_clk_o | output | 1 | Programmable divided clock |
| pix_phase_o | output | 1 | Serializer phase: 0 = pixel A, 1 = pixel B |

## Verification
A ratio commit and a mode change can land on the same edge. When that happens, the divided clock switches ratio while the load strobe and phase switch behaviour. The bench provokes this by stepping until the count is 31 and then changing `mux2_i` and `div_sel_i` together. It then compares all three outputs, cycle by cycle, against a model built from the requirements, for the whole of the following count period. A withdrawn request inside a period and a reset in the middle of a run are also driven, to show that neither disturbs the phase relationship.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

    typedef enum logic {
        SEL_HOLD = 1'b0,
        SEL_PEND = 1'b1
    } sel_state_e;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_RUN  = 1'b1
    } out_state_e;

endpackage

// File: rtl/vclk_phase_ctr.sv
module vclk_phase_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_comb begin
        if (rst_i) begin
            cnt_next_o = '0;
        end else begin
            cnt_next_o = cnt_o + CNT_W'(1);
        end
        wrap_o = (cnt_o == CNT_TOP) && !rst_i;
    end

    always_ff @(posedge clk_i) begin
        cnt_o <= cnt_next_o;
    end

endmodule

// File: rtl/vclk_sel_fsm.sv
module vclk_sel_fsm
    import vclk_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wrap_i,
    input  logic [SEL_W-1:0] sel_req_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [SEL_W-1:0] sel_act_o,
    output logic [SEL_W-1:0] sel_next_o
);

    sel_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_act_q;

    assign sel_act_o = sel_act_q;

    // next live ratio: loaded in reset and at the wrap only
    always_comb begin
        if (rst_i || wrap_i) begin
            sel_next_o = sel_req_i;
        end else begin
            sel_next_o = sel_act_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_HOLD: begin
                if (!wrap_i && (sel_req_i != sel_act_q)) begin
                    state_d = SEL_PEND;
                end
            end
            SEL_PEND: begin
                if (wrap_i || (sel_req_i == sel_act_q)) begin
                    state_d = SEL_HOLD;
                end
            end
            default: state_d = SEL_HOLD;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEL_HOLD;
        end else begin
            state_q <= state_d;
        end
        sel_act_q <= sel_next_o;
    end

    AST_SEL_AT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(sel_act_q) |-> (cnt_i == '0)); // R7

    AST_PEND_COMMITS: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SEL_PEND && wrap_i) |=>
            (state_q == SEL_HOLD && sel_act_q == $past(sel_req_i))); // R7

endmodule

// File: rtl/vclk_out_gen.sv
module vclk_out_gen
    import vclk_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             mux2_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [SEL_W-1:0] sel_next_i,
    output logic             load_o,
    output logic             phase_o,
    output logic             prog_o
);

    localparam int N_TAP = 2 ** SEL_W;

    out_state_e       state_q, state_d;
    logic             mode_q;
    logic [N_TAP-1:0] taps;

    // tap g gives divide by 2^(g+2)
    for (genvar g = 0; g < N_TAP; g++) begin : g_tap
        assign taps[g] = cnt_next_i[g+1];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: if (!rst_i) state_d = OUT_RUN;
            OUT_RUN:  if (rst_i)  state_d = OUT_IDLE;
            default:  state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q  <= 1'b0;
            load_o  <= 1'b0;
            phase_o <= 1'b0;
            prog_o  <= 1'b0;
        end else begin
            mode_q  <= mux2_i;
            load_o  <= mux2_i ? ~cnt_next_i[0] : 1'b1;
            phase_o <= mux2_i & cnt_next_i[0];
            prog_o  <= taps[sel_next_i];
        end
    end

    AST_PAIR_OPPOSED: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == OUT_RUN && mode_q) |-> (load_o != phase_o)); // R4

    AST_SINGLE_RATE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == OUT_RUN && !mode_q) |-> (load_o && !phase_o)); // R3

    AST_LOAD_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == OUT_RUN && $past(state_q) == OUT_RUN && mode_q && $past(mode_q))
            |-> (load_o != $past(load_o))); // R2

endmodule

// File: rtl/vclk_divider.sv
module vclk_divider #(
    parameter int CNT_W = 5,
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             mux2_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             load_clk_o,
    output logic             prog_clk_o,
    output logic             pix_phase_o
);

    logic [CNT_W-1:0] cnt, cnt_next;
    logic             wrap;
    logic [SEL_W-1:0] sel_act, sel_next;

    vclk_phase_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next),
        .wrap_o     (wrap)
    );

    vclk_sel_fsm #(.SEL_W(SEL_W), .CNT_W(CNT_W)) i_sel (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wrap_i     (wrap),
        .sel_req_i  (div_sel_i),
        .cnt_i      (cnt),
        .sel_act_o  (sel_act),
        .sel_next_o (sel_next)
    );

    vclk_out_gen #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_out (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mux2_i     (mux2_i),
        .cnt_next_i (cnt_next),
        .sel_next_i (sel_next),
        .load_o     (load_clk_o),
        .phase_o    (pix_phase_o),
        .prog_o     (prog_clk_o)
    );

    AST_PROG_LOW_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt == '0) |-> !prog_clk_o); // R6

    AST_PROG_RISE_EVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(prog_clk_o) |-> !cnt[0]); // R5

    AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap |=> (sel_act == $past(div_sel_i))); // R7

endmodule

// File: tb/test_vclk_divider.sv
module test_vclk_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mux2 = 1'b1;
    logic [1:0] dsel = 2'd3;
    logic       load_clk, prog_clk, pix_phase;

    always #4 clk = ~clk;

    vclk_divider i_vclk_divider (
        .clk_i       (clk),
        .rst_i       (rst),
        .mux2_i      (mux2),
        .div_sel_i   (dsel),
        .load_clk_o  (load_clk),
        .prog_clk_o  (prog_clk),
        .pix_phase_o (pix_phase)
    );

    typedef struct {
        logic  load;
        logic  phase;
        logic  prog;
        string tl;
        string tp;
        string tg;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    // model state, from the requirements
    int         c = 0;
    logic [1:0] sel_act = 2'd0;
    logic       last_mode = 1'b0;
    logic       r7_win = 1'b0;

    task automatic check_bit(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, name, act, exp);
        end
    endtask

    task automatic step(logic r, logic m, logic [1:0] s);
        exp_t e;
        @(negedge clk);
        rst  = r;
        mux2 = m;
        dsel = s;
        if (r) begin
            c = 0;
            sel_act = s;
            r7_win = 1'b0;
            last_mode = m;
            e.load = 1'b0; e.phase = 1'b0; e.prog = 1'b0;
            e.tl = "R1"; e.tp = "R1"; e.tg = "R1";
        end else begin
            logic wrap;
            wrap = (c == 31);
            c = (c + 1) % 32;
            if (wrap) begin
                r7_win = (sel_act != s);
                sel_act = s;
            end
            e.load  = m ? ((c % 2) == 0) : 1'b1;
            e.phase = m ? ((c % 2) == 1) : 1'b0;
            e.prog  = ((c >> (int'(sel_act) + 1)) % 2) == 1;
            if (m != last_mode) e.tl = "R8";
            else e.tl = m ? "R2" : "R3";
            e.tp = m ? "R4" : "R3";
            if (c == 0) e.tg = "R6";
            else if (r7_win || (s != sel_act)) e.tg = "R7";
            else e.tg = "R5";
            last_mode = m;
        end
        q.push_back(e);
    endtask

    task automatic run(int n, logic m, logic [1:0] s);
        for (int i = 0; i < n; i++) step(1'b0, m, s);
    endtask

    task automatic run_to(int target, logic m, logic [1:0] s);
        for (int i = 0; i < 64 && c != target; i++) step(1'b0, m, s);
    endtask

    // monitor: compares 2 ns after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check_bit(e.tl, "load_clk", load_clk, e.load);
                check_bit(e.tp, "pix_phase", pix_phase, e.phase);
                check_bit(e.tg, "prog_clk", prog_clk, e.prog);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with divide-by-32 requested
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'd3);
        // R2 R4 R5: 2:1 mode, /32
        run(80, 1'b1, 2'd3);
        // R7: request /4 mid period, takes effect at wrap
        run_to(10, 1'b1, 2'd3);
        run(60, 1'b1, 2'd0);
        // R7: withdrawn request has no effect
        run(3, 1'b1, 2'd2);
        run(40, 1'b1, 2'd0);
        // /8, then mode change and ratio commit on the same edge (R8, R7)
        run(40, 1'b1, 2'd1);
        run_to(31, 1'b1, 2'd1);
        step(1'b0, 1'b0, 2'd3);
        run(70, 1'b0, 2'd3);
        // R8: mode toggling every cycle
        for (int i = 0; i < 10; i++) step(1'b0, (i % 2) == 0, 2'd2);
        run(40, 1'b1, 2'd2);
        // R1: reset mid run selecting /8
        run_to(13, 1'b1, 2'd2);
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 2'd1);
        run(50, 1'b1, 2'd1);
        repeat (3) @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule